// File: doc/BRIEF.md
# Software-Recovery Fault Redirect Controller

This block is the recovery control for a simple in-order core that lets software mark regions of code as recoverable. A region-entry instruction carries the address of a software handler. A nonzero operand turns relaxed mode on and stores that address in a recovery PC register. A zero operand turns relaxed mode off and is used to close a region. An external detector reports faults a fixed number of cycles (`LAT`) after an instruction issues. The block keeps one tag per in-flight instruction in a shift register, so that each report is matched to the instruction it belongs to.

A fault on an instruction that issued inside a region makes the block redirect fetch to the stored handler. It rolls back nothing: results already committed stay in place, and the handler code does the recovery. A fault on an instruction that issued outside any region goes to an unrecoverable-fault output instead. Every trap request is held until detection for its instruction has finished. If that instruction faulted inside a region, the trap is dropped and the redirect goes ahead. An atomic operation issued while relaxed mode is on is flagged as illegal. A region entry made while already relaxed overwrites the handler address and pulses a nesting warning.

The issue port is valid-only and has no back-pressure: the core presents at most one instruction per cycle on `iss_valid`, and the block never stalls it. All other pins are plain control and status signals. Every output comes from a register. An issue is sampled at the clock edge that ends its cycle, and its fault report is sampled exactly `LAT` edges later.

Top module: `swrec_redirect_ctrl`

## Requirements
- R1: After reset, `relax_on`, `redir_valid`, `redir_pc`, `trap_release`, `trap_code`, `unrec_fault`, `illegal_atomic` and `nest_warn` are all 0, and no instruction is pending.
- R2: An issued region-entry (`iss_enter`=1) with a nonzero `iss_operand` sets `relax_on` from the next cycle and stores the operand as the handler address.
- R3: An issued region-entry with `iss_operand`=0 clears `relax_on` from the next cycle.
- R4: For an instruction issued at edge E while `relax_on` was 1, `flt_valid`=1 at edge E+LAT raises `redir_valid` for exactly one cycle after that edge, with `redir_pc` equal to the stored handler address. `relax_on` is unchanged by the redirect.
- R5: An instruction belongs to a region when `relax_on` was 1 as it issued; a region-entry or exit instruction itself is judged by the mode before its own effect. A fault matched to a non-region instruction pulses `unrec_fault` for one cycle and causes no redirect.
- R6: `flt_valid` at an edge where no instruction issued exactly `LAT` edges earlier has no effect on any output.
- R7: A trap request (`iss_trap`=1 with `iss_trap_code`) is held for every instruction. It appears as a one-cycle `trap_release` pulse with `trap_code` equal to the request code, after edge E+LAT, when there is no redirect.
- R8: When the faulting in-region instruction also requested a trap, the trap is dropped: `trap_release` stays 0 and only the redirect is raised.
- R9: A redirect discards every other pending instruction, so their later fault reports and traps produce no output. An issue presented at the same edge as the redirect decision is ignored: no mode change, no flag, and it is not tracked.
- R10: An atomic operation (`iss_atomic`=1) issued while `relax_on` is 1 pulses `illegal_atomic` for one cycle. Outside a region it raises nothing.
- R11: A region entry with a nonzero operand while `relax_on` is already 1 pulses `nest_warn` for one cycle, keeps `relax_on` at 1, and replaces the handler address used by later redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_enter | input | 1 | Issued instruction is a region entry or exit |
| iss_operand | input | AW | Handler address operand; zero means exit |
| iss_atomic | input | 1 | Issued instruction is an atomic operation |
| iss_trap | input | 1 | Issued instruction requests an exception |
| iss_trap_code | input | CW | Exception cause code |
| flt_valid | input | 1 | Fault report for the instruction issued LAT edges earlier |
| relax_on | output | 1 | Relaxed mode is active |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_pc | output | AW | Redirect target (handler address) |
| trap_release | output | 1 | One-cycle release of a deferred trap |
| trap_code | output | CW | Cause code of the released trap |
| unrec_fault | output | 1 | Fault on an instruction outside any region |
| illegal_atomic | output | 1 | Atomic operation issued inside a region |
| nest_warn | output | 1 | Region entered while already relaxed |

## Verification
The bench builds the block with `LAT`=3, `AW`=8 and `CW`=4. With a short pipeline it can sweep every combination of region membership, trap request and fault report for a single instruction. It can also sweep fault reports at every offset from one edge to `LAT`+2 edges after issue, so a report arriving one edge early or late is shown to be ignored. The three-stage depth also makes back-to-back in-flight instructions cheap to arrange, which brings the redirect-flush case within reach: two faulting instructions, with a region exit presented at the same edge as the redirect.

// File: rtl/swrec_pkg.sv
package swrec_pkg;

  // Tag carried by each in-flight instruction until its detection slot.
  typedef struct packed {
    logic vld;   // slot holds an issued instruction
    logic rlx;   // instruction issued with relaxed mode on
    logic trp;   // instruction requested a trap
  } trk_t;

  // Outcome of the detection slot at the head of the tracker.
  typedef enum logic [1:0] {
    HD_IDLE  = 2'd0,
    HD_CLEAN = 2'd1,
    HD_REDIR = 2'd2,
    HD_UNREC = 2'd3
  } head_res_e;

endpackage

// File: rtl/swrec_mode_unit.sv
module swrec_mode_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic          ev_enter,
  input  logic [AW-1:0] ev_operand,
  input  logic          ev_atomic,
  output logic          relax_q,
  output logic [AW-1:0] rpc_q,
  output logic          nest_q,
  output logic          illegal_q
);

  logic op_nonzero;
  logic enter_set;
  logic enter_clr;
  logic atomic_bad;

  always_comb begin
    op_nonzero = |ev_operand;
    enter_set  = ev_valid & ev_enter & op_nonzero;
    enter_clr  = ev_valid & ev_enter & ~op_nonzero;
    atomic_bad = ev_valid & ev_atomic & relax_q;
  end

  // Relaxed-mode flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      relax_q <= 1'b0;
    end else if (enter_set) begin
      relax_q <= 1'b1;
    end else if (enter_clr) begin
      relax_q <= 1'b0;
    end
  end

  // Recovery PC: loaded by every entry with a nonzero operand.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpc_q <= '0;
    end else if (enter_set) begin
      rpc_q <= ev_operand;
    end
  end

  // One-cycle status pulses.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nest_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      nest_q    <= enter_set & relax_q;
      illegal_q <= atomic_bad;
    end
  end

endmodule

// File: rtl/swrec_track_pipe.sv
module swrec_track_pipe
  import swrec_pkg::*;
#(
  parameter int LAT = 5,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  trk_t          push_tag,
  input  logic [CW-1:0] push_code,
  output trk_t          head_tag,
  output logic [CW-1:0] head_code
);

  localparam int LAST = LAT - 1;

  trk_t          tag_q  [LAT];
  logic [CW-1:0] code_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    trk_t          tag_d;
    logic [CW-1:0] code_d;

    if (g == 0) begin : g_entry
      always_comb begin
        tag_d  = push ? push_tag : '0;
        code_d = (push && push_tag.trp) ? push_code : '0;
      end
    end else begin : g_follow
      always_comb begin
        tag_d  = tag_q[g-1];
        code_d = code_q[g-1];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        tag_q[g]  <= '0;
        code_q[g] <= '0;
      end else begin
        tag_q[g]  <= tag_d;
        code_q[g] <= code_d;
      end
    end
  end

  always_comb begin
    head_tag  = tag_q[LAST];
    head_code = code_q[LAST];
  end

endmodule

// File: rtl/swrec_resolve.sv
module swrec_resolve
  import swrec_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  trk_t          head_tag,
  input  logic [CW-1:0] head_code,
  input  logic          flt_valid,
  input  logic [AW-1:0] rpc,
  output logic          flush,
  output logic          redir_q,
  output logic [AW-1:0] redir_pc_q,
  output logic          trap_rel_q,
  output logic [CW-1:0] trap_code_q,
  output logic          unrec_q
);

  head_res_e res;
  logic      release_trap;

  always_comb begin
    if (!head_tag.vld) begin
      res = HD_IDLE;
    end else if (!flt_valid) begin
      res = HD_CLEAN;
    end else if (head_tag.rlx) begin
      res = HD_REDIR;
    end else begin
      res = HD_UNREC;
    end
    flush        = (res == HD_REDIR);
    release_trap = head_tag.vld & head_tag.trp & (res != HD_REDIR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_q     <= 1'b0;
      redir_pc_q  <= '0;
      trap_rel_q  <= 1'b0;
      trap_code_q <= '0;
      unrec_q     <= 1'b0;
    end else begin
      redir_q     <= (res == HD_REDIR);
      unrec_q     <= (res == HD_UNREC);
      trap_rel_q  <= release_trap;
      trap_code_q <= release_trap ? head_code : '0;
      if (res == HD_REDIR) begin
        redir_pc_q <= rpc;
      end
    end
  end

endmodule

// File: rtl/swrec_redirect_ctrl.sv
module swrec_redirect_ctrl
  import swrec_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 5,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_enter,
  input  logic [AW-1:0] iss_operand,
  input  logic          iss_atomic,
  input  logic          iss_trap,
  input  logic [CW-1:0] iss_trap_code,
  input  logic          flt_valid,
  output logic          relax_on,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          trap_release,
  output logic [CW-1:0] trap_code,
  output logic          unrec_fault,
  output logic          illegal_atomic,
  output logic          nest_warn
);

  logic          flush;
  logic          iss_go;
  logic          relax_q;
  logic [AW-1:0] rpc_q;
  trk_t          push_tag;
  trk_t          head_tag;
  logic [CW-1:0] head_code;

  // An issue coinciding with a redirect decision is squashed.
  always_comb begin
    iss_go       = iss_valid & ~flush;
    push_tag.vld = 1'b1;
    push_tag.rlx = relax_q;
    push_tag.trp = iss_trap;
  end

  swrec_mode_unit #(.AW(AW)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (iss_go),
    .ev_enter   (iss_enter),
    .ev_operand (iss_operand),
    .ev_atomic  (iss_atomic),
    .relax_q    (relax_q),
    .rpc_q      (rpc_q),
    .nest_q     (nest_warn),
    .illegal_q  (illegal_atomic)
  );

  swrec_track_pipe #(.LAT(LAT), .CW(CW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (iss_go),
    .push_tag  (push_tag),
    .push_code (iss_trap_code),
    .head_tag  (head_tag),
    .head_code (head_code)
  );

  swrec_resolve #(.AW(AW), .CW(CW)) u_resolve (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_tag    (head_tag),
    .head_code   (head_code),
    .flt_valid   (flt_valid),
    .rpc         (rpc_q),
    .flush       (flush),
    .redir_q     (redir_valid),
    .redir_pc_q  (redir_pc),
    .trap_rel_q  (trap_release),
    .trap_code_q (trap_code),
    .unrec_q     (unrec_fault)
  );

  assign relax_on = relax_q;

endmodule

// File: rtl/swrec_redirect_ctrl_chk.sv
module swrec_redirect_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic iss_valid,
  input logic iss_atomic,
  input logic flt_valid,
  input logic relax_on,
  input logic redir_valid,
  input logic trap_release,
  input logic unrec_fault,
  input logic illegal_atomic,
  input logic nest_warn
);

  // R9: a redirect flushes everything, so it never repeats next cycle
  assert_single_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  // R8: redirect wins over a deferred trap
  assert_redirect_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !trap_release);

  // R5: a fault is either recoverable or not, never both
  assert_redir_not_unrec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !unrec_fault);

  // R6: no fault report, no fault outcome
  assert_no_fault_no_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flt_valid) |-> (!redir_valid && !unrec_fault));

  // R4: relaxed mode is untouched by the redirect edge
  assert_mode_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $stable(relax_on));

  // R10: the illegal flag needs a relaxed issue of an atomic
  assert_atomic_in_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_atomic |-> ($past(relax_on) && $past(iss_valid) && $past(iss_atomic)));

  // R11: a nesting warning leaves relaxed mode on
  assert_nest_keeps_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nest_warn |-> relax_on);

endmodule

bind swrec_redirect_ctrl swrec_redirect_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iss_valid      (iss_valid),
  .iss_atomic     (iss_atomic),
  .flt_valid      (flt_valid),
  .relax_on       (relax_on),
  .redir_valid    (redir_valid),
  .trap_release   (trap_release),
  .unrec_fault    (unrec_fault),
  .illegal_atomic (illegal_atomic),
  .nest_warn      (nest_warn)
);

// File: tb/sim_swrec_redirect_ctrl.sv
module sim_swrec_redirect_ctrl;

  localparam int TCLK = 10;
  localparam int AW   = 8;
  localparam int CW   = 4;
  localparam int LAT  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic          iss_enter;
  logic [AW-1:0] iss_operand;
  logic          iss_atomic;
  logic          iss_trap;
  logic [CW-1:0] iss_trap_code;
  logic          flt_valid;
  logic          relax_on;
  logic          redir_valid;
  logic [AW-1:0] redir_pc;
  logic          trap_release;
  logic [CW-1:0] trap_code;
  logic          unrec_fault;
  logic          illegal_atomic;
  logic          nest_warn;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  swrec_redirect_ctrl #(.AW(AW), .CW(CW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_enter(iss_enter),
    .iss_operand(iss_operand), .iss_atomic(iss_atomic), .iss_trap(iss_trap),
    .iss_trap_code(iss_trap_code), .flt_valid(flt_valid), .relax_on(relax_on),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .trap_release(trap_release),
    .trap_code(trap_code), .unrec_fault(unrec_fault),
    .illegal_atomic(illegal_atomic), .nest_warn(nest_warn)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    iss_valid = 0; iss_enter = 0; iss_operand = '0; iss_atomic = 0;
    iss_trap = 0; iss_trap_code = '0; flt_valid = 0;
  endtask

  // Outputs are read 1 time unit after the edge; inputs change there too.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input string req);
    check({req, " redir"}, int'(redir_valid), 0);
    check({req, " unrec"}, int'(unrec_fault), 0);
    check({req, " trap"},  int'(trap_release), 0);
  endtask

  // Region entry/exit, then drain so it cannot collide with later slots.
  task automatic set_mode(input logic [AW-1:0] op);
    iss_valid = 1; iss_enter = 1; iss_operand = op;
    tick(); clr();
    check("R2/R3 relax_on after entry", int'(relax_on), int'(op != 0));
    for (int k = 0; k < LAT + 1; k++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) tick();
    // R1: reset state
    check("R1 relax_on", int'(relax_on), 0);
    check("R1 redir_valid", int'(redir_valid), 0);
    check("R1 redir_pc", int'(redir_pc), 0);
    check("R1 trap_release", int'(trap_release), 0);
    check("R1 trap_code", int'(trap_code), 0);
    check("R1 unrec_fault", int'(unrec_fault), 0);
    check("R1 illegal_atomic", int'(illegal_atomic), 0);
    check("R1 nest_warn", int'(nest_warn), 0);
    rst_n = 1;
    tick();

    // Sweep: region membership x trap x fault for one instruction (R4 R5 R7 R8)
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 2; t++) begin
        for (int f = 0; f < 2; f++) begin
          logic [AW-1:0] hnd;
          logic [CW-1:0] cd;
          hnd = AW'(8'h40 + m * 16 + t * 4 + f);
          cd  = CW'(m * 4 + t * 2 + f + 1);
          set_mode(m ? hnd : '0);
          iss_valid = 1; iss_trap = t[0]; iss_trap_code = cd;
          tick(); clr();
          for (int k = 1; k < LAT; k++) begin
            tick();
            quiet("R7 held before detection");
          end
          flt_valid = f[0];
          tick(); clr();
          check("R4 redirect", int'(redir_valid), m & f);
          if (m == 1 && f == 1) begin
            check("R4 redir_pc", int'(redir_pc), int'(hnd));
            check("R4 relax_on kept", int'(relax_on), 1);
          end
          check("R5 unrec_fault", int'(unrec_fault), (1 - m) & f);
          check("R7/R8 trap_release", int'(trap_release), t & ~(m & f) & 1);
          check("R7 trap_code", int'(trap_code), (t & ~(m & f) & 1) ? int'(cd) : 0);
          tick();
          quiet("R4 single-cycle pulse");
        end
      end
    end

    // R6: mistimed fault reports have no effect
    set_mode(8'h5A);
    for (int d = 1; d <= LAT + 2; d++) begin
      if (d == LAT) continue;
      iss_valid = 1; iss_trap = 1; iss_trap_code = 4'h9;
      tick(); clr();
      for (int k = 1; k <= LAT + 2; k++) begin
        flt_valid = (k == d);
        tick();
        flt_valid = 0;
        check("R6 no redirect on mistimed fault", int'(redir_valid), 0);
        check("R6 no unrec on mistimed fault", int'(unrec_fault), 0);
        if (k == LAT) check("R6 trap still released", int'(trap_release), 1);
      end
    end

    // R5: entry instruction is judged by the mode before it
    set_mode('0);
    iss_valid = 1; iss_enter = 1; iss_operand = 8'h44;
    tick(); clr();
    for (int k = 1; k < LAT; k++) tick();
    flt_valid = 1; tick(); clr();
    check("R5 entry instr fault unrec", int'(unrec_fault), 1);
    check("R5 entry instr no redirect", int'(redir_valid), 0);
    // exit instruction issued in region counts as in-region
    iss_valid = 1; iss_enter = 1; iss_operand = '0;
    tick(); clr();
    check("R3 exit clears", int'(relax_on), 0);
    for (int k = 1; k < LAT; k++) tick();
    flt_valid = 1; tick(); clr();
    check("R5 exit instr redirects", int'(redir_valid), 1);
    check("R5 exit instr target", int'(redir_pc), 8'h44);
    tick();

    // R9: two faulting instructions, exit issued at the redirect edge
    set_mode(8'h3C);
    iss_valid = 1; iss_trap = 1; iss_trap_code = 4'h1;
    tick();
    iss_trap_code = 4'h2;
    tick(); clr();
    for (int k = 2; k < LAT; k++) tick();
    flt_valid = 1; iss_valid = 1; iss_enter = 1; iss_operand = '0;
    tick(); clr();
    check("R9 first fault redirects", int'(redir_valid), 1);
    check("R9 target", int'(redir_pc), 8'h3C);
    check("R8 trap dropped", int'(trap_release), 0);
    check("R9 concurrent exit squashed", int'(relax_on), 1);
    flt_valid = 1;
    tick(); clr();
    check("R9 second fault flushed", int'(redir_valid), 0);
    check("R9 second trap flushed", int'(trap_release), 0);
    check("R9 second not unrec", int'(unrec_fault), 0);

    // R10: atomic inside vs outside a region
    set_mode('0);
    iss_valid = 1; iss_atomic = 1; tick(); clr();
    check("R10 atomic outside", int'(illegal_atomic), 0);
    set_mode(8'h21);
    iss_valid = 1; iss_atomic = 1; tick(); clr();
    check("R10 atomic inside", int'(illegal_atomic), 1);
    tick();
    check("R10 pulse ends", int'(illegal_atomic), 0);

    // R11: nested entry
    set_mode('0);
    iss_valid = 1; iss_enter = 1; iss_operand = 8'h11; tick(); clr();
    check("R11 first entry no warn", int'(nest_warn), 0);
    iss_valid = 1; iss_enter = 1; iss_operand = 8'h22; tick(); clr();
    check("R11 nest_warn", int'(nest_warn), 1);
    check("R11 relax_on kept", int'(relax_on), 1);
    tick();
    check("R11 warn one cycle", int'(nest_warn), 0);
    iss_valid = 1; tick(); clr();
    for (int k = 1; k < LAT; k++) tick();
    flt_valid = 1; tick(); clr();
    check("R11 redirect uses new handler", int'(redir_pc), 8'h22);
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule